// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block decides how a power stage reacts when a sense-resistor comparator reports an overcurrent. It takes an already synchronized overcurrent flag and applies one of four policies selected by a 2-bit mode field. A separate disable bit can suppress the reaction entirely. The block drives one enable signal shared by all power switches and an active-low fault pin. It also holds two latched status bits, a general fault bit and an overcurrent bit, which a register interface elsewhere reads.

A latched fault is cleared in one of two ways. The first is a single-cycle clear strobe from the register space. The second is a reset pulse on the enable pin, meaning a low pulse whose length falls inside a programmed window. In the timed retry policy, the fault releases by itself once a parameterised retry period has run out, counted from the cycle of detection. The mode field is captured when a fault is taken. A change to the mode field while a fault is held does nothing until that fault is gone.

Top module: `ocp_resp_ctrl`

## Requirements
- R1: Out of reset, drv_en_o=1, fault_n_o=1, stat_fault_o=0 and stat_oc_o=0.
- R2: Mode 2'b00 (latched shutdown) works as follows. The clock edge that samples oc_flag_i=1 while no fault is held sets drv_en_o=0, fault_n_o=0 and both status bits to 1.
- R3: In mode 2'b00 and in mode 2'b10, a held fault releases on the edge that sees a clear event while oc_flag_i=0. A clear event is clr_strobe_i=1 or a valid enable-pin reset pulse. A clear that arrives while oc_flag_i=1 has no effect, and oc_flag_i falling with no clear also has no effect.
- R4: Mode 2'b01 (auto-retry) gives drv_en_o=0, fault_n_o=0 and both status bits set for exactly RETRY_CYCLES cycles from the detection edge. After that the fault releases with no clear, and clr_strobe_i during the period has no effect.
- R5: Mode 2'b10 (report only) keeps drv_en_o=1 while it drives fault_n_o=0 and sets both status bits.
- R6: Mode 2'b11, or sense_dis_i=1, makes oc_flag_i=1 change no output.
- R7: A low pulse on en_pin_i counts as a clear only if it covers L rising clock edges with RST_MIN <= L < SLEEP_CYC. Shorter and longer pulses are ignored.
- R8: The policy of a held fault is the one captured at detection. A new mode_i value applies only to faults detected after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag_i | input | 1 | Synchronized overcurrent flag, 1 = overcurrent |
| mode_i | input | 2 | Response policy: 00 latch, 01 retry, 10 report, 11 ignore |
| sense_dis_i | input | 1 | 1 = overcurrent detection disabled |
| clr_strobe_i | input | 1 | Single-cycle clear-faults strobe |
| en_pin_i | input | 1 | Enable pin, watched for a reset pulse |
| drv_en_o | output | 1 | 1 = power switches may be driven |
| fault_n_o | output | 1 | Active-low fault pin |
| stat_fault_o | output | 1 | Latched general fault bit |
| stat_oc_o | output | 1 | Latched overcurrent bit |

## Verification
The assertions check several things on every cycle. Detection in latch and report mode drives the right outputs on the next edge, and ignore mode or the disable bit leaves the fault pin released. A held latch or report fault never releases while the flag is still high, and a retry fault never leaves early. Every pulse the enable detector emits follows a return of the pin to high. The bench scenarios are what show the rest. They cover the exact retry length, the lower and upper bounds of the enable-pulse window, a clear strobe arriving under an active condition, and a mode change made while a fault is held.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_RETRY  = 2'd2,
        ST_REPORT = 2'd3
    } ocp_state_e;

    localparam logic [1:0] MODE_LATCH  = 2'b00;
    localparam logic [1:0] MODE_RETRY  = 2'b01;
    localparam logic [1:0] MODE_REPORT = 2'b10;
    localparam logic [1:0] MODE_IGNORE = 2'b11;

endpackage

// File: rtl/ocp_evt_qual.sv
module ocp_evt_qual
    import ocp_pkg::*;
(
    input  logic       oc_flag_i,
    input  logic [1:0] mode_i,
    input  logic       sense_dis_i,
    output logic       evt_o,
    output ocp_state_e tgt_o
);

    always_comb begin
        evt_o = oc_flag_i && !sense_dis_i && (mode_i != MODE_IGNORE);
        unique case (mode_i)
            MODE_LATCH:  tgt_o = ST_LATCH;
            MODE_RETRY:  tgt_o = ST_RETRY;
            MODE_REPORT: tgt_o = ST_REPORT;
            default:     tgt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ocp_retry_tmr.sv
module ocp_retry_tmr #(
    parameter int RETRY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);

    localparam int CW = $clog2(RETRY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RETRY_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = LOAD_VAL;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = (r_q.cnt == '0);

endmodule

// File: rtl/ocp_en_pulse.sv
module ocp_en_pulse #(
    parameter int RST_MIN   = 8,
    parameter int SLEEP_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin_i,
    output logic pulse_o
);

    localparam int PW = $clog2(SLEEP_CYC + 1);
    localparam logic [PW-1:0] LO_LIM  = PW'(RST_MIN);
    localparam logic [PW-1:0] HI_LIM  = PW'(SLEEP_CYC);

    typedef struct packed {
        logic [PW-1:0] low_cnt;
        logic          pulse;
    } det_s;

    det_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (!en_pin_i) begin
            if (r_q.low_cnt != HI_LIM) begin
                r_d.low_cnt = r_q.low_cnt + 1'b1;
            end
        end else begin
            r_d.pulse   = (r_q.low_cnt >= LO_LIM) && (r_q.low_cnt < HI_LIM);
            r_d.low_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_o = r_q.pulse;

    // R7
    pulse_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(en_pin_i));

endmodule

// File: rtl/ocp_resp_ctrl.sv
module ocp_resp_ctrl
    import ocp_pkg::*;
#(
    parameter int RETRY_CYCLES = 1000,
    parameter int RST_MIN      = 8,
    parameter int SLEEP_CYC    = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_flag_i,
    input  logic [1:0] mode_i,
    input  logic       sense_dis_i,
    input  logic       clr_strobe_i,
    input  logic       en_pin_i,
    output logic       drv_en_o,
    output logic       fault_n_o,
    output logic       stat_fault_o,
    output logic       stat_oc_o
);

    typedef struct packed {
        ocp_state_e st;
    } ctl_s;

    ctl_s r_d, r_q;

    logic       evt;
    ocp_state_e tgt;
    logic       tmr_load;
    logic       tmr_done;
    logic       en_pulse;
    logic       clr_evt;

    ocp_evt_qual u_qual (
        .oc_flag_i   (oc_flag_i),
        .mode_i      (mode_i),
        .sense_dis_i (sense_dis_i),
        .evt_o       (evt),
        .tgt_o       (tgt)
    );

    ocp_retry_tmr #(.RETRY_CYCLES(RETRY_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .done_o (tmr_done)
    );

    ocp_en_pulse #(.RST_MIN(RST_MIN), .SLEEP_CYC(SLEEP_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_pin_i (en_pin_i),
        .pulse_o  (en_pulse)
    );

    assign clr_evt = clr_strobe_i || en_pulse;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (evt) begin
                    r_d.st   = tgt;
                    tmr_load = (tgt == ST_RETRY);
                end
            end
            ST_LATCH, ST_REPORT: begin
                if (clr_evt && !oc_flag_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_RETRY: begin
                if (tmr_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_en_o     = (r_q.st == ST_IDLE) || (r_q.st == ST_REPORT);
    assign fault_n_o    = (r_q.st == ST_IDLE);
    assign stat_fault_o = (r_q.st != ST_IDLE);
    assign stat_oc_o    = (r_q.st != ST_IDLE);

    // R2
    shutdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n_o && oc_flag_i && !sense_dis_i && mode_i == MODE_LATCH)
        |=> (!drv_en_o && !fault_n_o && stat_oc_o));

    // R5
    report_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n_o && oc_flag_i && !sense_dis_i && mode_i == MODE_REPORT)
        |=> (drv_en_o && !fault_n_o && stat_fault_o));

    // R6
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n_o && (sense_dis_i || mode_i == MODE_IGNORE)) |=> fault_n_o);

    // R3
    hold_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_LATCH || r_q.st == ST_REPORT) && oc_flag_i) |=> !fault_n_o);

    // R4
    retry_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RETRY && !tmr_done) |=> (!fault_n_o && !drv_en_o));

endmodule

// File: tb/tb_ocp_resp_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_resp_ctrl;

    localparam int RC  = 20;
    localparam int RMN = 4;
    localparam int SLP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oc_flag_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       sense_dis_i = 1'b0;
    logic       clr_strobe_i = 1'b0;
    logic       en_pin_i = 1'b1;
    logic       drv_en_o, fault_n_o, stat_fault_o, stat_oc_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ocp_resp_ctrl #(.RETRY_CYCLES(RC), .RST_MIN(RMN), .SLEEP_CYC(SLP)) dut (
        .clk(clk), .rst_n(rst_n), .oc_flag_i(oc_flag_i), .mode_i(mode_i),
        .sense_dis_i(sense_dis_i), .clr_strobe_i(clr_strobe_i), .en_pin_i(en_pin_i),
        .drv_en_o(drv_en_o), .fault_n_o(fault_n_o),
        .stat_fault_o(stat_fault_o), .stat_oc_o(stat_oc_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected outputs packed as {drv_en, fault_n, stat_fault, stat_oc}
    task automatic expect_out(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {drv_en_o, fault_n_o, stat_fault_o, stat_oc_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
        end
    endtask

    localparam logic [3:0] NORMAL  = 4'b1100;
    localparam logic [3:0] SHUT    = 4'b0011;
    localparam logic [3:0] REPORTD = 4'b1011;

    task automatic pulse_clr();
        clr_strobe_i = 1'b1;
        step(1);
        clr_strobe_i = 1'b0;
    endtask

    task automatic latch_fault(input logic [1:0] m);
        mode_i = m;
        oc_flag_i = 1'b1;
        step(1);
        oc_flag_i = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1 reset state", NORMAL);
    endtask

    task automatic t_latch();
        mode_i = 2'b00;
        oc_flag_i = 1'b1;
        step(1);
        expect_out("R2 latch entry", SHUT);
        pulse_clr();
        step(1);
        expect_out("R3 clear while condition present", SHUT);
        oc_flag_i = 1'b0;
        step(3);
        expect_out("R3 condition gone without clear", SHUT);
        pulse_clr();
        expect_out("R3 strobe releases latch", NORMAL);
    endtask

    task automatic t_retry();
        mode_i = 2'b01;
        oc_flag_i = 1'b1;
        step(1);
        oc_flag_i = 1'b0;
        expect_out("R4 retry entry", SHUT);
        step(4);
        pulse_clr();
        step(1);
        expect_out("R4 clear during retry ignored", SHUT);
        step(RC - 1 - 6);
        expect_out("R4 last retry cycle", SHUT);
        step(1);
        expect_out("R4 auto release after period", NORMAL);
    endtask

    task automatic t_report();
        mode_i = 2'b10;
        oc_flag_i = 1'b1;
        step(1);
        expect_out("R5 report keeps drivers", REPORTD);
        oc_flag_i = 1'b0;
        step(3);
        expect_out("R3 report held without clear", REPORTD);
        pulse_clr();
        expect_out("R3 report released", NORMAL);
    endtask

    task automatic t_ignore();
        mode_i = 2'b11;
        oc_flag_i = 1'b1;
        step(3);
        expect_out("R6 mode 11 ignored", NORMAL);
        mode_i = 2'b00;
        sense_dis_i = 1'b1;
        step(3);
        expect_out("R6 disable bit ignored", NORMAL);
        oc_flag_i = 1'b0;
        sense_dis_i = 1'b0;
        step(1);
    endtask

    task automatic en_low(input int len);
        en_pin_i = 1'b0;
        step(len);
        en_pin_i = 1'b1;
        step(2);
    endtask

    task automatic t_en_pulse();
        latch_fault(2'b00);
        en_low(RMN - 1);
        expect_out("R7 short enable pulse ignored", SHUT);
        en_low(RMN);
        expect_out("R7 minimum enable pulse clears", NORMAL);
        latch_fault(2'b00);
        en_low(SLP);
        expect_out("R7 sleep-length pulse ignored", SHUT);
        en_low(SLP - 1);
        expect_out("R7 longest valid pulse clears", NORMAL);
    endtask

    task automatic t_mode_change();
        latch_fault(2'b00);
        mode_i = 2'b10;
        step(2);
        expect_out("R8 mode change while latched", SHUT);
        mode_i = 2'b01;
        step(RC + 5);
        expect_out("R8 retry mode not applied to held fault", SHUT);
        pulse_clr();
        expect_out("R8 release by clear", NORMAL);
        mode_i = 2'b10;
        oc_flag_i = 1'b1;
        step(1);
        oc_flag_i = 1'b0;
        expect_out("R8 new mode used after release", REPORTD);
        pulse_clr();
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_latch();
        t_retry();
        t_report();
        t_ignore();
        t_en_pulse();
        t_mode_change();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule